// File: doc/BRIEF.md
# Processor Memory Bus Interface

This block sits between the single internal bus of a 32-bit processor datapath and an external word-addressed memory. It holds two registers. The address register takes its value from the internal bus and presents it on the external address lines. The data buffer register takes its value either from the internal bus or from the external read data, and presents it either on the internal bus or on the external write data lines. The controller raises separate load and output-enable strobes to move words through the block. The block issues the memory read and write strobes itself, and only for legal accesses.

Tri-state behaviour is expressed as a value port paired with an output-enable port. The pad ring or the bus fabric applies the enable, so a port whose enable is low is high-impedance on the wire. The external memory presents a word as byte lanes, and lane k holds the byte at address+k. The block assembles words big-endian: the byte at the lowest address lands in bits 31..24. It checks that every access is word-aligned and that reads and writes are never requested together.

Top module: `membus_if`

## Requirements
- R1: After synchronous reset the address register and data buffer both hold zero, and both error flags are low.
- R2: When `ld_mar` is high at a clock edge, the address register takes `int_bus_i`. Otherwise it keeps its value, whatever the internal bus carries.
- R3: `addr_oe_o` equals `mar_out` in the same cycle, and `addr_o` always shows the address register.
- R4: When `ld_mbr` and `int2mbr` are both high and `mem_rd` is low, the data buffer takes `int_bus_i` at the edge. With `ld_mbr` low it holds its value even if `int2mbr` is high.
- R5: A read is issued (`rd_stb_o` high, in the same cycle) when `mem_rd` is high, `mem_wr` is low and address bits 1..0 are zero. With `ld_mbr` high the buffer then loads the memory word, and this source takes priority over `int2mbr`.
- R6: Read data is assembled big-endian. Lane k (bits 8k+7..8k of `mem_rdata_i`, the byte at address+k) goes to word bits 31-8k..24-8k. Bytes 07h, 85h, E5h, 3Dh at addresses +0..+3 read as 0785E53Dh.
- R7: A write is issued (`wr_stb_o` high, in the same cycle) when `mem_wr` is high, `mem_rd` is low and the address is aligned. Only then is `mem_wdata_oe_o` high. `mem_wdata_o` lane k carries buffer bits 31-8k..24-8k.
- R8: `int_oe_o` equals `mbr_out` in the same cycle, and `int_bus_o` always shows the data buffer.
- R9: A read or write request whose address bits 1..0 are non-zero issues no strobe and does not drive write data. A blocked read leaves the buffer unchanged. `err_align_o` is high in the cycle after the request.
- R10: When `mem_rd` and `mem_wr` are high together, no strobe is issued and `err_proto_o` is high in the cycle after.
- R11: In a cycle with neither `mem_rd` nor `mem_wr` high, both strobes and `mem_wdata_oe_o` are low, and both error flags are low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_bus_i | input | 32 | Internal processor bus value |
| ld_mar | input | 1 | Load address register from internal bus |
| mar_out | input | 1 | Enable address register onto external address lines |
| ld_mbr | input | 1 | Load data buffer (source chosen by int2mbr / mem_rd) |
| int2mbr | input | 1 | Select internal bus as data buffer source |
| mbr_out | input | 1 | Enable data buffer onto internal bus |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| mem_rdata_i | input | 32 | External read data, byte lane k = byte at address+k |
| addr_o | output | 32 | External address value |
| addr_oe_o | output | 1 | Output enable for addr_o |
| int_bus_o | output | 32 | Data buffer value toward internal bus |
| int_oe_o | output | 1 | Output enable for int_bus_o |
| mem_wdata_o | output | 32 | External write data, byte lane k = byte for address+k |
| mem_wdata_oe_o | output | 1 | Output enable for mem_wdata_o |
| rd_stb_o | output | 1 | Issued memory read strobe |
| wr_stb_o | output | 1 | Issued memory write strobe |
| err_align_o | output | 1 | Misaligned request seen in the previous cycle |
| err_proto_o | output | 1 | Read and write requested together in the previous cycle |

## Verification
Two functions can meet in one cycle. A memory read that loads the data buffer can coincide with a select of the internal bus as source, and a misaligned address can coincide with a read/write conflict. The bench raises `int2mbr` with a driven internal-bus pattern on every other word of a full read sweep, and expects the memory word to win. It then requests misaligned reads and writes, and reads and writes together, at both aligned and misaligned addresses. After each of these it checks that no strobe fired and that the buffer and the memory model's bytes are untouched. It also checks that exactly the expected error flags rise one cycle later.

// File: rtl/membus_pkg.sv
package membus_pkg;

  // Source chosen for the data buffer at the next clock edge.
  typedef enum logic [1:0] {
    BUF_HOLD     = 2'd0,
    BUF_FROM_INT = 2'd1,
    BUF_FROM_MEM = 2'd2
  } buf_src_e;

  // Registered error flags.
  typedef struct packed {
    logic align;
    logic proto;
  } bus_err_t;

endpackage

// File: rtl/mbi_addr_reg.sv
module mbi_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/mbi_access_ctrl.sv
module mbi_access_ctrl #(
  parameter int ALIGN_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_rd,
  input  logic                  req_wr,
  input  logic [ALIGN_BITS-1:0] addr_low,
  output logic                  rd_stb,
  output logic                  wr_stb,
  output membus_pkg::bus_err_t  err
);

  logic aligned;
  logic conflict;
  logic any_req;

  assign aligned  = (addr_low == '0);
  assign conflict = req_rd & req_wr;
  assign any_req  = req_rd | req_wr;

  // Strobes go out in the request cycle so a single-cycle memory can answer.
  assign rd_stb = req_rd & ~req_wr & aligned;
  assign wr_stb = req_wr & ~req_rd & aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= '0;
    end else begin
      err.align <= any_req & ~aligned;
      err.proto <= conflict;
    end
  end

endmodule

// File: rtl/mbi_data_buf.sv
module mbi_data_buf #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  membus_pkg::buf_src_e src,
  input  logic [DATA_W-1:0]    int_d,
  input  logic [DATA_W-1:0]    mem_lanes,
  output logic [DATA_W-1:0]    q,
  output logic [DATA_W-1:0]    wr_lanes
);

  import membus_pkg::*;

  localparam int LANES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] mem_word;

  // Big-endian lane mapping: lane 0 (lowest address) <-> most significant byte.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mem_word[DATA_W-1-k*BYTE_W -: BYTE_W] = mem_lanes[k*BYTE_W +: BYTE_W];
    assign wr_lanes[k*BYTE_W +: BYTE_W]          = q[DATA_W-1-k*BYTE_W -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (src)
        BUF_FROM_INT: q <= int_d;
        BUF_FROM_MEM: q <= mem_word;
        default:      q <= q;
      endcase
    end
  end

endmodule

// File: rtl/membus_if.sv
module membus_if #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] int_bus_i,
  input  logic              ld_mar,
  input  logic              mar_out,
  input  logic              ld_mbr,
  input  logic              int2mbr,
  input  logic              mbr_out,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] int_bus_o,
  output logic              int_oe_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_wdata_oe_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic              err_align_o,
  output logic              err_proto_o
);

  import membus_pkg::*;

  localparam int LANES      = DATA_W / BYTE_W;
  localparam int ALIGN_BITS = $clog2(LANES);

  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q;
  logic              rd_stb;
  logic              wr_stb;
  bus_err_t          err;
  buf_src_e          buf_src;

  mbi_addr_reg #(.ADDR_W(ADDR_W)) u_mar (
    .clk  (clk),
    .rst  (rst),
    .load (ld_mar),
    .d    (int_bus_i[ADDR_W-1:0]),
    .q    (mar_q)
  );

  mbi_access_ctrl #(.ALIGN_BITS(ALIGN_BITS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_rd   (mem_rd),
    .req_wr   (mem_wr),
    .addr_low (mar_q[ALIGN_BITS-1:0]),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .err      (err)
  );

  // Memory wins over the internal bus; a blocked read holds the buffer.
  always_comb begin
    buf_src = BUF_HOLD;
    if (ld_mbr) begin
      if (rd_stb) begin
        buf_src = BUF_FROM_MEM;
      end else if (int2mbr && !mem_rd) begin
        buf_src = BUF_FROM_INT;
      end
    end
  end

  mbi_data_buf #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mbr (
    .clk       (clk),
    .rst       (rst),
    .src       (buf_src),
    .int_d     (int_bus_i),
    .mem_lanes (mem_rdata_i),
    .q         (mbr_q),
    .wr_lanes  (mem_wdata_o)
  );

  assign addr_o         = mar_q;
  assign addr_oe_o      = mar_out;
  assign int_bus_o      = mbr_q;
  assign int_oe_o       = mbr_out;
  assign mem_wdata_oe_o = wr_stb;
  assign rd_stb_o       = rd_stb;
  assign wr_stb_o       = wr_stb;
  assign err_align_o    = err.align;
  assign err_proto_o    = err.proto;

endmodule

// File: rtl/membus_if_chk.sv
module membus_if_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] int_bus_i,
  input logic              ld_mar,
  input logic              ld_mbr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] int_bus_o,
  input logic              mem_wdata_oe_o,
  input logic              rd_stb_o,
  input logic              wr_stb_o,
  input logic              err_align_o,
  input logic              err_proto_o
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int AB    = $clog2(LANES);

  function automatic logic [DATA_W-1:0] swap_lanes(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      r[DATA_W-1-k*BYTE_W -: BYTE_W] = v[k*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  p_mar_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld_mar |=> addr_o == $past(int_bus_i[ADDR_W-1:0]));

  p_mar_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ld_mar |=> $stable(addr_o));

  p_mbr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_mbr |=> $stable(int_bus_o));

  p_read_word_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_o && ld_mbr) |=> int_bus_o == swap_lanes($past(mem_rdata_i)));

  p_wdata_only_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wdata_oe_o |-> (mem_wr && !mem_rd));

  p_rd_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    rd_stb_o |-> addr_o[AB-1:0] == '0);

  p_wr_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> addr_o[AB-1:0] == '0);

  p_align_flag_r9: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && addr_o[AB-1:0] != '0) |=> err_align_o);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb_o && wr_stb_o));

  p_proto_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wr) |=> err_proto_o);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd || mem_wr) |=> (!err_align_o && !err_proto_o));

endmodule

bind membus_if membus_if_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .int_bus_i      (int_bus_i),
  .ld_mar         (ld_mar),
  .ld_mbr         (ld_mbr),
  .mem_rd         (mem_rd),
  .mem_wr         (mem_wr),
  .mem_rdata_i    (mem_rdata_i),
  .addr_o         (addr_o),
  .int_bus_o      (int_bus_o),
  .mem_wdata_oe_o (mem_wdata_oe_o),
  .rd_stb_o       (rd_stb_o),
  .wr_stb_o       (wr_stb_o),
  .err_align_o    (err_align_o),
  .err_proto_o    (err_proto_o)
);

// File: tb/membus_if_bench.sv
`timescale 1ns/1ps
module membus_if_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] int_bus_i = '0;
  logic        ld_mar = 0, mar_out = 0, ld_mbr = 0, int2mbr = 0, mbr_out = 0;
  logic        mem_rd = 0, mem_wr = 0;
  logic [31:0] mem_rdata_i;
  logic [31:0] addr_o, int_bus_o, mem_wdata_o;
  logic        addr_oe_o, int_oe_o, mem_wdata_oe_o, rd_stb_o, wr_stb_o;
  logic        err_align_o, err_proto_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  membus_if u_membus_if (
    .clk(clk), .rst(rst), .int_bus_i(int_bus_i), .ld_mar(ld_mar), .mar_out(mar_out),
    .ld_mbr(ld_mbr), .int2mbr(int2mbr), .mbr_out(mbr_out), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata_i(mem_rdata_i), .addr_o(addr_o), .addr_oe_o(addr_oe_o), .int_bus_o(int_bus_o),
    .int_oe_o(int_oe_o), .mem_wdata_o(mem_wdata_o), .mem_wdata_oe_o(mem_wdata_oe_o),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .err_align_o(err_align_o), .err_proto_o(err_proto_o)
  );

  // 64-byte memory model: asynchronous read lanes, write on the clock edge.
  logic [7:0] bmem [64];

  function automatic logic [7:0] init_byte(input int i);
    case (i)
      0: return 8'h07;
      1: return 8'h85;
      2: return 8'hE5;
      3: return 8'h3D;
      default: return 8'((i * 29 + 11) & 255);
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) bmem[i] <= init_byte(i);
    end else if (wr_stb_o) begin
      for (int k = 0; k < 4; k++) bmem[{addr_o[5:2], 2'(k)}] <= mem_wdata_o[8*k +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) mem_rdata_i[8*k +: 8] = bmem[{addr_o[5:2], 2'(k)}];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    ld_mar = 0; mar_out = 0; ld_mbr = 0; int2mbr = 0; mbr_out = 0; mem_rd = 0; mem_wr = 0;
  endtask

  task automatic set_mar(input logic [31:0] a);
    idle(); ld_mar = 1; int_bus_i = a; cyc(); ld_mar = 0;
  endtask

  task automatic set_mbr(input logic [31:0] v);
    idle(); ld_mbr = 1; int2mbr = 1; int_bus_i = v; cyc(); ld_mbr = 0; int2mbr = 0;
  endtask

  function automatic logic [31:0] word_at(input int a);
    return {init_byte(a), init_byte(a + 1), init_byte(a + 2), init_byte(a + 3)};
  endfunction

  function automatic logic [31:0] lanes_of(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp, keep;
    logic [7:0]  sv [4];
    idle();
    repeat (3) cyc();
    rst = 0;
    cyc();

    // R1 reset state, R3 / R8 enables follow their strobes
    chk(err_align_o == 0 && err_proto_o == 0, "R1 flags", {30'd0, err_align_o, err_proto_o}, 0);
    mar_out = 1; mbr_out = 1; #1;
    chk(addr_o == 0, "R1 mar", addr_o, 0);
    chk(int_bus_o == 0, "R1 mbr", int_bus_o, 0);
    chk(addr_oe_o == 1, "R3 oe on", {31'd0, addr_oe_o}, 1);
    chk(int_oe_o == 1, "R8 oe on", {31'd0, int_oe_o}, 1);
    chk(!rd_stb_o && !wr_stb_o && !mem_wdata_oe_o, "R11 quiet", {29'd0, rd_stb_o, wr_stb_o, mem_wdata_oe_o}, 0);
    idle(); #1;
    chk(addr_oe_o == 0 && int_oe_o == 0, "R3 R8 oe off", {30'd0, addr_oe_o, int_oe_o}, 0);

    // R2 address register load and hold
    for (int i = 0; i < 8; i++) begin
      v = (32'h1234_5679 * (i + 1)) ^ (i << 3);
      set_mar(v);
      int_bus_i = ~v; cyc();
      chk(addr_o == v, "R2 load/hold", addr_o, v);
    end

    // R5 / R6 read sweep over every aligned word; int2mbr raised on odd words
    for (int k = 0; k < 16; k++) begin
      set_mar(32'h00AB_1240 + 4 * k);
      mem_rd = 1; ld_mbr = 1; int2mbr = k[0]; int_bus_i = 32'hDEAD_0000 | k; mar_out = 1; #1;
      chk(rd_stb_o == 1 && wr_stb_o == 0, "R5 rd strobe", {30'd0, rd_stb_o, wr_stb_o}, 2);
      cyc(); idle(); mbr_out = 1; #1;
      exp = word_at(4 * k);
      chk(int_bus_o == exp, "R5 R6 read word", int_bus_o, exp);
      chk(!err_align_o && !err_proto_o, "R11 no error", {30'd0, err_align_o, err_proto_o}, 0);
      if (k == 0) chk(int_bus_o == 32'h0785_E53D, "R6 example", int_bus_o, 32'h0785_E53D);
    end

    // R4 internal load and hold when ld_mbr low
    for (int k = 0; k < 8; k++) begin
      v = 32'hC001_0000 ^ (32'h0101_0101 * k);
      set_mbr(v);
      chk(int_bus_o == v, "R4 int load", int_bus_o, v);
      int2mbr = 1; int_bus_i = ~v; cyc(); int2mbr = 0;
      chk(int_bus_o == v, "R4 hold", int_bus_o, v);
    end

    // R7 write sweep with lane check and memory model bytes
    for (int k = 0; k < 16; k++) begin
      v = 32'hA1B2_C3D4 ^ (32'h0103_0507 * k);
      set_mbr(v);
      set_mar(4 * k);
      mem_wr = 1; #1;
      chk(wr_stb_o == 1 && mem_wdata_oe_o == 1 && rd_stb_o == 0, "R7 wr strobe",
          {29'd0, wr_stb_o, mem_wdata_oe_o, rd_stb_o}, 6);
      chk(mem_wdata_o == lanes_of(v), "R7 lanes", mem_wdata_o, lanes_of(v));
      cyc(); idle();
      exp = {bmem[4*k], bmem[4*k+1], bmem[4*k+2], bmem[4*k+3]};
      chk(exp == v, "R7 memory bytes", exp, v);
    end

    // R9 misaligned reads and writes
    for (int off = 1; off < 4; off++) begin
      for (int dir = 0; dir < 2; dir++) begin
        keep = 32'h5A5A_0000 | (off << 4) | dir;
        set_mbr(keep);
        for (int j = 0; j < 4; j++) sv[j] = bmem[8 + j];
        set_mar(8 + off);
        mem_rd = (dir == 0); mem_wr = (dir == 1); ld_mbr = 1; #1;
        chk(!rd_stb_o && !wr_stb_o && !mem_wdata_oe_o, "R9 no strobe",
            {29'd0, rd_stb_o, wr_stb_o, mem_wdata_oe_o}, 0);
        cyc(); idle();
        chk(err_align_o && !err_proto_o, "R9 flag", {30'd0, err_align_o, err_proto_o}, 2);
        chk(int_bus_o == keep, "R9 buffer kept", int_bus_o, keep);
        exp = {bmem[8], bmem[9], bmem[10], bmem[11]};
        chk(exp == {sv[0], sv[1], sv[2], sv[3]}, "R9 memory kept", exp, {sv[0], sv[1], sv[2], sv[3]});
      end
    end

    // R10 read and write together, aligned then misaligned
    for (int off = 0; off < 2; off++) begin
      keep = 32'h0BAD_F00D + off;
      set_mbr(keep);
      for (int j = 0; j < 4; j++) sv[j] = bmem[12 + j];
      set_mar(12 + off);
      mem_rd = 1; mem_wr = 1; ld_mbr = 1; int2mbr = 1; int_bus_i = 32'hFFFF_FFFF; #1;
      chk(!rd_stb_o && !wr_stb_o && !mem_wdata_oe_o, "R10 no strobe",
          {29'd0, rd_stb_o, wr_stb_o, mem_wdata_oe_o}, 0);
      cyc(); idle();
      chk(err_proto_o && (err_align_o == (off != 0)), "R10 flags",
          {30'd0, err_align_o, err_proto_o}, {30'd0, 1'(off != 0), 1'b1});
      chk(int_bus_o == keep, "R10 buffer kept", int_bus_o, keep);
      exp = {bmem[12], bmem[13], bmem[14], bmem[15]};
      chk(exp == {sv[0], sv[1], sv[2], sv[3]}, "R10 memory kept", exp, {sv[0], sv[1], sv[2], sv[3]});
      cyc();
      chk(!err_align_o && !err_proto_o, "R11 flags clear", {30'd0, err_align_o, err_proto_o}, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule